// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one general-purpose I/O port of up to sixteen pins, reached through a plain word-addressed register bus. Software drives pins through an output latch gated by a per-pin direction bit. It reads pin levels back through a two-flop synchroniser. Each pin can also raise an interrupt. A programmable trigger decides which pin activity sets a sticky status bit: rising edge, falling edge, either edge, high level or low level. Status bits that are enabled and not masked are ORed into one interrupt line.

Bus reads are combinational. Writes take effect on the clock edge at which `bus_sel` and `bus_wr` are both high. A small two-state controller handles the port's software reset:

- **RUN** is the normal state.
- **HELD** forces every port register to its reset value and ignores writes to those registers.
- **RUN → HELD** is taken when a 1 is written to bit 0 of the reset word.
- **HELD → RUN** is taken when a 0 is written to bit 0 of the reset word.

Word addresses are as follows:

| Address | Register |
|---|---|
| 0 | enable |
| 1 | raw status |
| 2 | visible status |
| 3 | status clear |
| 4 | mask set |
| 5 | mask clear |
| 6 | output data |
| 7 | input data |
| 8 | direction |
| 9 | trigger A |
| 10 | trigger B |
| 11 | reserved |
| 12 | reset control |

Top module: `gpio_irq_port`

## Requirements
- R1: After `rst_n` is released, every register reads zero, `irq` is 0 and `pin_oe` is 0.
- R2: The enable (0) and output data (6) words read back what was last written, in the low NPINS bits. Direction (8) keeps only its low NPINS bits, and the rest read zero.
- R3: `pin_oe` equals the direction word. `pin_out[i]` equals output data bit i when direction bit i is 1, and is 0 otherwise.
- R4: The input data word (7) returns `pin_in` delayed by two clock edges. One edge after a change it still shows the old level.
- R5: The trigger code of pin i sits in bits [4k+2:4k] of a nibble, where k = i for pins 0–7 in word 9 and k = i−8 for pins 8–15 in word 10. Bit 3 of each nibble reads 0.
- R6: Trigger codes are 0 for falling edge, 1 for rising edge and 4 for either edge. An enabled pin in an edge mode sets its status bit on the matching transition of its synchronised level, and keeps it until it is cleared.
- R7: Trigger code 3 (high level) and code 2 (low level) set the status bit on every cycle the level is present. A clear issued while the level persists leaves the bit at 1.
- R8: Writing word 3 clears each status bit whose data bit is 1. Bits written as 0 are unaffected. A trigger event in the same cycle as the clear wins.
- R9: Writing word 4 sets the mask bits written as 1, and writing word 5 clears the mask bits written as 1. Zero bits are ignored in both. Word 4 reads the current mask and word 5 reads zero.
- R10: Word 2 returns status AND NOT mask. `irq` is 1 exactly when that value is nonzero.
- R11: A pin whose enable bit is 0 never sets its status bit.
- R12: Writing 1 to bit 0 of word 12 enters HELD. In HELD all port registers read zero and writes to them are ignored. Writing 0 to word 12 returns to RUN, and word 12 bit 0 reads 1 only in HELD.
- R13: Trigger codes 5–7 never set status. Words 3, 5 and 11 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data |
| pin_in | input | NPINS | Pin levels, asynchronous |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The checker assumes the bus carries one access per cycle with a stable address and data. It also assumes `pin_in` changes no faster than the synchroniser can follow, so that every level reaches the detectors.

The bench drives all bus and pin inputs on the falling clock edge and holds each pin pattern for four cycles before it reads status. Writes to the clear and mask words are single-cycle pulses.

The mode sweep covers all eight trigger codes against pin transitions computed in the bench. The clear-all property can therefore see both cases: a clear with no event, and a clear that a persisting level overrides.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Trigger codes per pin
    localparam logic [2:0] TRIG_FALL = 3'd0;
    localparam logic [2:0] TRIG_RISE = 3'd1;
    localparam logic [2:0] TRIG_LOW  = 3'd2;
    localparam logic [2:0] TRIG_HIGH = 3'd3;
    localparam logic [2:0] TRIG_BOTH = 3'd4;

    // Word addresses
    localparam int ADDR_ENABLE = 0;
    localparam int ADDR_STATUS = 1;
    localparam int ADDR_VIS    = 2;
    localparam int ADDR_CLEAR  = 3;
    localparam int ADDR_MSET   = 4;
    localparam int ADDR_MCLR   = 5;
    localparam int ADDR_DOUT   = 6;
    localparam int ADDR_DIN    = 7;
    localparam int ADDR_DIR    = 8;
    localparam int ADDR_TRIG_A = 9;
    localparam int ADDR_TRIG_B = 10;
    localparam int ADDR_RSVD   = 11;
    localparam int ADDR_SRST   = 12;

    localparam int PINS_PER_TRIG = 8;

    typedef enum logic {PORT_RUN, PORT_HELD} port_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= d;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic       lvl,
    input  logic       lvl_prev,
    input  logic [2:0] trig,
    output logic       hit
);
    always_comb begin
        case (trig)
            TRIG_FALL: hit = lvl_prev & ~lvl;
            TRIG_RISE: hit = ~lvl_prev & lvl;
            TRIG_LOW:  hit = ~lvl;
            TRIG_HIGH: hit = lvl;
            TRIG_BOTH: hit = lvl_prev ^ lvl;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    localparam int NIB = 4;

    port_state_e st_q, st_d;
    logic        port_held;

    logic [NPINS-1:0] en_q, status_q, mask_q, dout_q, dir_q;
    logic [NPINS-1:0] lvl, lvl_prev, hit, vis;
    logic [2:0]       trig_q [NPINS];
    logic [DW-1:0]    trig_a_rd, trig_b_rd;

    logic wr_any;
    logic wr_en, wr_clr, wr_mset, wr_mclr, wr_dout, wr_dir, wr_ta, wr_tb, wr_srst;
    logic [NPINS-1:0] wbits, clr_bits, set_bits, unset_bits;

    assign wr_any  = bus_sel & bus_wr;
    assign wr_en   = wr_any && (bus_addr == AW'(ADDR_ENABLE));
    assign wr_clr  = wr_any && (bus_addr == AW'(ADDR_CLEAR));
    assign wr_mset = wr_any && (bus_addr == AW'(ADDR_MSET));
    assign wr_mclr = wr_any && (bus_addr == AW'(ADDR_MCLR));
    assign wr_dout = wr_any && (bus_addr == AW'(ADDR_DOUT));
    assign wr_dir  = wr_any && (bus_addr == AW'(ADDR_DIR));
    assign wr_ta   = wr_any && (bus_addr == AW'(ADDR_TRIG_A));
    assign wr_tb   = wr_any && (bus_addr == AW'(ADDR_TRIG_B));
    assign wr_srst = wr_any && (bus_addr == AW'(ADDR_SRST));

    assign wbits      = bus_wdata[NPINS-1:0];
    assign clr_bits   = wr_clr  ? wbits : '0;
    assign set_bits   = wr_mset ? wbits : '0;
    assign unset_bits = wr_mclr ? wbits : '0;

    // Reset-control state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PORT_RUN;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PORT_RUN:  if (wr_srst &&  bus_wdata[0]) st_d = PORT_HELD;
            PORT_HELD: if (wr_srst && !bus_wdata[0]) st_d = PORT_RUN;
        endcase
    end

    // Outputs of the state machine
    always_comb port_held = (st_q == PORT_HELD);

    gpio_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .d        (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    // Per-pin trigger storage and detection
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam int  K  = i % PINS_PER_TRIG;
        localparam bit  HI = (i >= PINS_PER_TRIG);
        logic wr_mine;
        assign wr_mine = HI ? wr_tb : wr_ta;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         trig_q[i] <= TRIG_FALL;
            else if (port_held) trig_q[i] <= TRIG_FALL;
            else if (wr_mine)   trig_q[i] <= bus_wdata[NIB*K +: 3];
        end

        gpio_pin_detect u_det (
            .lvl      (lvl[i]),
            .lvl_prev (lvl_prev[i]),
            .trig     (trig_q[i]),
            .hit      (hit[i])
        );
    end

    // Port registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0; status_q <= '0; mask_q <= '0; dout_q <= '0; dir_q <= '0;
        end else if (port_held) begin
            en_q <= '0; status_q <= '0; mask_q <= '0; dout_q <= '0; dir_q <= '0;
        end else begin
            if (wr_en)   en_q   <= wbits;
            if (wr_dout) dout_q <= wbits;
            if (wr_dir)  dir_q  <= wbits;
            mask_q   <= (mask_q | set_bits) & ~unset_bits;
            status_q <= (status_q & ~clr_bits) | (hit & en_q);
        end
    end

    // Packed trigger read-back
    always_comb begin
        trig_a_rd = '0;
        trig_b_rd = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (i < PINS_PER_TRIG)
                trig_a_rd[NIB*i +: NIB] = {1'b0, trig_q[i]};
            else
                trig_b_rd[NIB*(i-PINS_PER_TRIG) +: NIB] = {1'b0, trig_q[i]};
        end
    end

    assign vis     = status_q & ~mask_q;
    assign irq     = |vis;
    assign pin_oe  = dir_q;
    assign pin_out = dout_q & dir_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(ADDR_ENABLE): bus_rdata[NPINS-1:0] = en_q;
            AW'(ADDR_STATUS): bus_rdata[NPINS-1:0] = status_q;
            AW'(ADDR_VIS):    bus_rdata[NPINS-1:0] = vis;
            AW'(ADDR_MSET):   bus_rdata[NPINS-1:0] = mask_q;
            AW'(ADDR_DOUT):   bus_rdata[NPINS-1:0] = dout_q;
            AW'(ADDR_DIN):    bus_rdata[NPINS-1:0] = lvl;
            AW'(ADDR_DIR):    bus_rdata[NPINS-1:0] = dir_q;
            AW'(ADDR_TRIG_A): bus_rdata = trig_a_rd;
            AW'(ADDR_TRIG_B): bus_rdata = trig_b_rd;
            AW'(ADDR_SRST):   bus_rdata[0] = port_held;
            default:          bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic             held,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] hit
);
    logic wr_to_enable, clear_all, mset_wr;
    assign wr_to_enable = bus_sel && bus_wr && (bus_addr == AW'(ADDR_ENABLE));
    assign clear_all    = bus_sel && bus_wr && (bus_addr == AW'(ADDR_CLEAR))
                          && (bus_wdata[NPINS-1:0] == '1);
    assign mset_wr      = bus_sel && bus_wr && (bus_addr == AW'(ADDR_MSET));

    // R12
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (status_q == '0 && !irq));

    // R10
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);

    // R3
    no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '0) |-> (pin_out == '0));

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all && hit == '0 && !held) |=> (status_q == '0));

    // R11
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0 && status_q == '0 && !wr_to_enable) |=> (status_q == '0));

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mset_wr && !held) |=>
        ((mask_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .held      (port_held),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .en_q      (en_q),
    .hit       (hit)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    localparam int NPINS = 16;
    localparam int DW    = 32;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0;
    logic             bus_wr = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [DW-1:0]    bus_wdata = '0;
    logic [DW-1:0]    bus_rdata;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_out, pin_oe;
    logic             irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_port #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] lvl_of(input int m, input logic [15:0] v);
        if (m == 3) return v;
        if (m == 2) return ~v;
        return 16'h0;
    endfunction

    function automatic logic [15:0] edge_of(input int m, input logic [15:0] q, input logic [15:0] p);
        if (m == 0) return q & ~p;
        if (m == 1) return ~q & p;
        if (m == 4) return q ^ p;
        return 16'h0;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] qs [4];
        logic [15:0] ps [4];
        qs[0] = 16'h0000; ps[0] = 16'hFFFF;
        qs[1] = 16'hFFFF; ps[1] = 16'h0000;
        qs[2] = 16'h0F0F; ps[2] = 16'h3C3C;
        qs[3] = 16'hA5A5; ps[3] = 16'h5A5A;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every word reads zero after reset
        for (int a = 0; a < 13; a++) begin
            rd(a, d);
            chk($sformatf("R1 word %0d", a), d, 32'h0);
        end
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);

        // R2: plain read/write words
        wr(0, 32'hFFFF_A5C3); rd(0, d); chk("R2 enable", d, 32'h0000_A5C3);
        wr(6, 32'h1234_1234); rd(6, d); chk("R2 dout", d, 32'h0000_1234);
        wr(8, 32'hFFFF_FFFF); rd(8, d); chk("R2 dir", d, (32'h1 << NPINS) - 1);
        wr(0, 32'h0);

        // R3: output drive follows direction
        wr(8, 32'h0000_00FF); wr(6, 32'h0000_5A5A);
        chk("R3 pin_oe", {16'h0, pin_oe}, 32'h0000_00FF);
        chk("R3 pin_out", {16'h0, pin_out}, 32'h0000_005A);

        // R4: two-edge input synchroniser
        @(negedge clk);
        pin_in = 16'hBEEF; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(7);
        @(negedge clk); #1 chk("R4 one edge", bus_rdata, 32'h0);
        @(negedge clk); #1 chk("R4 two edges", bus_rdata, 32'h0000_BEEF);
        bus_sel = 1'b0;

        // R5: trigger nibble layout
        wr(9, 32'hFFFF_FFFF);  rd(9, d);  chk("R5 trig A", d, 32'h7777_7777);
        wr(10, 32'h4321_0F0F); rd(10, d); chk("R5 trig B", d, 32'h4321_0707);

        // R6 R7 R13: sweep every trigger code against pin patterns
        wr(0, 32'h0000_FFFF);
        wr(5, 32'h0000_FFFF);
        for (int m = 0; m < 8; m++) begin
            wr(9,  {8{4'(m)}});
            wr(10, {8{4'(m)}});
            for (int k = 0; k < 4; k++) begin
                logic [15:0] after_clr;
                logic [15:0] exp_st;
                pin_in = qs[k];
                settle();
                wr(3, 32'h0000_FFFF);
                after_clr = lvl_of(m, qs[k]);
                rd(1, d);
                chk($sformatf("R7 R8 mode %0d pat %0d after clear", m, k), d, {16'h0, after_clr});
                pin_in = ps[k];
                settle();
                exp_st = after_clr | edge_of(m, qs[k], ps[k]) | lvl_of(m, ps[k]);
                rd(1, d);
                chk($sformatf("R6 R13 mode %0d pat %0d status", m, k), d, {16'h0, exp_st});
                chk($sformatf("R10 mode %0d pat %0d irq", m, k), {31'h0, irq}, {31'h0, exp_st != 0});
            end
        end

        // R11: disabled pins stay clear
        wr(9, 32'h4444_4444); wr(10, 32'h4444_4444);
        pin_in = 16'h0000; settle();
        wr(0, 32'h0000_00FF); wr(3, 32'h0000_FFFF);
        pin_in = 16'hFFFF; settle();
        rd(1, d); chk("R11 partial enable", d, 32'h0000_00FF);

        // R8: partial and zero clears
        wr(0, 32'h0000_FFFF);
        pin_in = 16'h0000; settle();
        rd(1, d); chk("R8 setup", d, 32'h0000_FFFF);
        wr(3, 32'h0000_00F0); rd(1, d); chk("R8 partial clear", d, 32'h0000_FF0F);
        wr(3, 32'h0000_0000); rd(1, d); chk("R8 zero clear", d, 32'h0000_FF0F);

        // R9 R10: mask set / clear
        wr(4, 32'h0000_000F); rd(4, d); chk("R9 mask set", d, 32'h0000_000F);
        rd(2, d); chk("R10 visible", d, 32'h0000_FF00);
        chk("R10 irq on", {31'h0, irq}, 32'h1);
        wr(4, 32'h0); rd(4, d); chk("R9 zero set ignored", d, 32'h0000_000F);
        wr(4, 32'h0000_FF00); rd(2, d); chk("R10 all masked", d, 32'h0);
        chk("R10 irq off", {31'h0, irq}, 32'h0);
        wr(5, 32'h0000_0100); rd(4, d); chk("R9 mask clear", d, 32'h0000_FE0F);
        rd(2, d); chk("R10 unmasked one", d, 32'h0000_0100);
        chk("R10 irq back", {31'h0, irq}, 32'h1);
        rd(5, d);  chk("R13 mask clear reads zero", d, 32'h0);
        rd(3, d);  chk("R13 clear reads zero", d, 32'h0);
        rd(11, d); chk("R13 reserved reads zero", d, 32'h0);

        // R12: software reset sequence
        wr(12, 32'h1); settle();
        rd(12, d); chk("R12 held flag", d, 32'h1);
        wr(0, 32'h0000_1234);
        rd(0, d); chk("R12 write ignored", d, 32'h0);
        rd(1, d); chk("R12 status zero", d, 32'h0);
        rd(4, d); chk("R12 mask zero", d, 32'h0);
        chk("R12 irq", {31'h0, irq}, 32'h0);
        chk("R12 pin_oe", {16'h0, pin_oe}, 32'h0);
        wr(12, 32'h0);
        rd(12, d); chk("R12 run flag", d, 32'h0);
        rd(9, d);  chk("R12 trig reset", d, 32'h0);
        wr(0, 32'h0000_0011); rd(0, d); chk("R12 writes resume", d, 32'h0000_0011);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule